// File: doc/BRIEF.md
# Parallel-to-serial shift register with gated clock pair

The block captures a parallel word and sends it out one bit at a time. It is modelled as synchronous logic on a fast system clock. The external pins (the parallel word, the serial fill bit, an active-low load control and two shift-clock pins) are first passed through two-flop synchronizers. An edge detector then finds the effective shift edge.

The two clock pins are equivalent, and the effective shift clock is their logical OR. This lets either pin serve as a clock inhibit: holding one pin high masks the other. A rising inhibit while the other pin is low counts as a shift edge of its own, and the block reproduces that behaviour on purpose.

While the load control is low, the parallel word is copied into every stage on each system clock, so the register tracks the inputs and keeps the last word present. While the load control is high, each effective rising edge moves the chain one place toward the output. The fill bit enters stage 0, and stage W-1 drives the true and complemented serial outputs.

Top module: `piso_shreg`

## Requirements
- R1: While rst_ni is low and after it is released with all pins idle (load control high, both clock pins low), q_o is 0 and q_no is 1.
- R2: While ld_ni is low, the register holds par_i, with bit W-1 on q_o, whatever the clock pins do; no shift occurs.
- R3: While ld_ni stays low, changes on par_i are followed, and the word present just before ld_ni rises is the word retained.
- R4: With ld_ni high, each rising edge of (ck_a_i OR ck_b_i) moves stage i into stage i+1, loads ser_i into stage 0, and makes the old stage W-2 appear on q_o.
- R5: ck_a_i and ck_b_i act identically as the shift clock.
- R6: While one clock pin is held high, transitions on the other pin cause no shift.
- R7: A clock pin that rises while the other pin is low causes exactly one shift.
- R8: A clock pin that rises while the other pin is already high causes no shift.
- R9: q_no is always the inverse of q_o.
- R10: A pin change made before system clock edge k shows on q_o after edge k+2 and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, fast relative to the pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| par_i | input | W | Parallel word |
| ser_i | input | 1 | Serial fill bit entering stage 0 |
| ld_ni | input | 1 | Active-low load control |
| ck_a_i | input | 1 | Shift clock pin A |
| ck_b_i | input | 1 | Shift clock pin B, interchangeable with A |
| q_o | output | 1 | Serial output, last stage |
| q_no | output | 1 | Complemented serial output |

## Verification
Directed sequences cover each corner of the gated clock. Pin A clocks while pin B is low, and then the roles are swapped, which separates a correct OR from a design that uses one pin alone. A rising inhibit over a low partner must produce one shift, while the same inhibit over a high partner must produce none; together these separate an OR-edge design from one that treats the inhibit as a pure mask. Toggling the clock pins while the load control is low, and changing the word during that time, confirms that loading wins and that the last word is kept. Random single-pin changes from a fixed seed then mix all of these against a reference register in the bench. A latency probe pins the number of synchronizer stages.

// File: rtl/piso_pkg.sv
package piso_pkg;
  localparam int unsigned PISO_W = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic ld_n;
    logic ser;
    logic ck_a;
    logic ck_b;
  } piso_ctl_t;

  localparam int unsigned CTL_W = $bits(piso_ctl_t);
  localparam piso_ctl_t CTL_IDLE = '{ld_n: 1'b1, ser: 1'b0, ck_a: 1'b0, ck_b: 1'b0};
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] flop_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flop_q[s] <= RST_VAL;
      end else begin
        flop_q[s] <= (s == 0) ? d_i : flop_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = flop_q[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ck_a_i,
  input  logic ck_b_i,
  output logic edge_o
);
  logic ck_or, ck_or_q;

  // either pin high drives the gated clock; a rising inhibit is a real edge
  assign ck_or = ck_a_i | ck_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ck_or_q <= 1'b0;
    else         ck_or_q <= ck_or;
  end

  assign edge_o = ck_or & ~ck_or_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);  // R7
  AST_INHIBIT_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ck_a_i) && ck_a_i) |-> !edge_o);  // R6
endmodule

// File: rtl/piso_chain.sv
module piso_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_ni,
  input  logic         shift_i,
  input  logic         ser_i,
  input  logic [W-1:0] par_i,
  output logic         msb_o
);
  logic [W-1:0] stage_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic shift_in;
    if (i == 0) begin : g_head
      assign shift_in = ser_i;
    end else begin : g_link
      assign shift_in = stage_q[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stage_q[i] <= 1'b0;
      else if (!ld_ni)   stage_q[i] <= par_i[i];
      else if (shift_i)  stage_q[i] <= shift_in;
    end
  end

  assign msb_o = stage_q[W-1];

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ni |=> stage_q == $past(par_i));  // R2
  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ni && shift_i) |=> stage_q == {$past(stage_q[W-2:0]), $past(ser_i)});  // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ni && !shift_i) |=> $stable(stage_q));  // R8
endmodule

// File: rtl/piso_shreg.sv
module piso_shreg
  import piso_pkg::*;
#(
  parameter int unsigned W = PISO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] par_i,
  input  logic         ser_i,
  input  logic         ld_ni,
  input  logic         ck_a_i,
  input  logic         ck_b_i,
  output logic         q_o,
  output logic         q_no
);
  piso_ctl_t    ctl_raw, ctl_s;
  logic [W-1:0] par_s;
  logic         shift;

  assign ctl_raw = '{ld_n: ld_ni, ser: ser_i, ck_a: ck_a_i, ck_b: ck_b_i};

  piso_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  piso_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_par_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (par_i),
    .q_o   (par_s)
  );

  piso_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ck_a_i(ctl_s.ck_a),
    .ck_b_i(ctl_s.ck_b),
    .edge_o(shift)
  );

  piso_chain #(.W(W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_ni  (ctl_s.ld_n),
    .shift_i(shift),
    .ser_i  (ctl_s.ser),
    .par_i  (par_s),
    .msb_o  (q_o)
  );

  assign q_no = ~q_o;

  AST_OUT_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_no != q_o);  // R9
endmodule

// File: tb/piso_shreg_bench.sv
module piso_shreg_bench;
  localparam int unsigned W = 8;
  localparam int unsigned MAX_CYCLES = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] par = '0;
  logic         ser = 1'b0;
  logic         ld_n = 1'b1;
  logic         ck_a = 1'b0;
  logic         ck_b = 1'b0;
  logic         q, q_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;  // 125 MHz

  piso_shreg #(.W(W)) u_piso_shreg (
    .clk_i(clk), .rst_ni(rst_n), .par_i(par), .ser_i(ser),
    .ld_ni(ld_n), .ck_a_i(ck_a), .ck_b_i(ck_b), .q_o(q), .q_no(q_n)
  );

  function automatic logic [W-1:0] next_model(logic [W-1:0] cur, logic [W-1:0] p,
      logic s, logic ldn, logic old_or, logic new_or);
    if (!ldn) return p;
    if (new_or && !old_or) return {cur[W-2:0], s};
    return cur;
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic apply(logic [W-1:0] p, logic s, logic ldn, logic a, logic b, string tag);
    logic old_or;
    old_or = ck_a | ck_b;
    par = p; ser = s; ld_n = ldn; ck_a = a; ck_b = b;
    model = next_model(model, p, s, ldn, old_or, a | b);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tag, q, model[W-1]);
    chk("R9", q_n, ~model[W-1]);
  endtask

  initial begin
    #(MAX_CYCLES * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", q, 1'b0);
    chk("R1", q_n, 1'b1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", q, 1'b0);
    chk("R1", q_n, 1'b1);

    // R2: load while clocks toggle
    apply(8'hA5, 0, 0, 0, 0, "R2");
    apply(8'hA5, 0, 0, 1, 0, "R2");
    apply(8'hA5, 0, 0, 0, 0, "R2");
    apply(8'hA5, 0, 0, 0, 1, "R2");
    apply(8'hA5, 0, 0, 0, 0, "R2");
    // R3: follow, keep last word
    apply(8'h3C, 0, 0, 0, 0, "R3");
    apply(8'h3C, 0, 1, 0, 0, "R3");
    apply(8'hFF, 0, 1, 0, 0, "R3");
    // R4/R5: shift via pin A, then pin B
    for (int i = 0; i < 4; i++) begin
      apply(8'hFF, i[0], 1, 1, 0, "R4");
      apply(8'hFF, i[0], 1, 0, 0, "R4");
    end
    for (int i = 0; i < 4; i++) begin
      apply(8'hFF, 1, 1, 0, 1, "R5");
      apply(8'hFF, 1, 1, 0, 0, "R5");
    end
    // R6: A held high, B toggles
    apply(8'h00, 0, 0, 0, 0, "R2");
    apply(8'h80, 0, 0, 0, 0, "R2");
    apply(8'h80, 0, 1, 0, 0, "R6");
    apply(8'h80, 0, 1, 1, 0, "R7");
    for (int i = 0; i < 3; i++) begin
      apply(8'h80, 0, 1, 1, 1, "R8");
      apply(8'h80, 0, 1, 1, 0, "R6");
    end
    // R7: inhibit rises while other low -> one shift
    apply(8'h80, 0, 0, 0, 0, "R2");
    apply(8'h80, 0, 1, 0, 0, "R7");
    apply(8'h80, 0, 1, 0, 1, "R7");
    chk("R7", q, 1'b0);
    // R10: latency of three system edges
    apply(8'h00, 0, 1, 0, 0, "R10");
    @(negedge clk);
    ld_n = 1'b0; par = 8'h80;
    model = 8'h80;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10", q, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R10", q, 1'b1);

    // random single-pin changes, fixed seed
    void'($urandom(32'd12345));
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] p;
      logic s, l, a, b;
      p = par; s = ser; l = ld_n; a = ck_a; b = ck_b;
      case ($urandom_range(0, 5))
        0: p = W'($urandom);
        1: s = ~s;
        2: l = ($urandom_range(0, 3) == 0) ? 1'b0 : 1'b1;
        3: a = ~a;
        4: b = ~b;
        default: begin a = ~a; end
      endcase
      apply(p, s, l, a, b, "R4");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule